// File: doc/BRIEF.md
# Subframe Doppler DC Notch

This block sits between a Doppler transform and a detection stage. It removes stationary clutter and slow drift from a range-Doppler map by forcing to zero the complex samples whose Doppler bin lies near the edges of a subframe. Each range bin carries 32 Doppler bins. These are handled as two independent subframes of 16 bins, so the same edge rule is applied to bins 0..15 and to bins 16..31. The rule is the same for every range bin.

The samples arrive as a stream. Each valid beat carries an I/Q pair and its Doppler bin index. A small unsigned width input sets how many bins are removed. The position of a bin inside its subframe is the low four bits of its index. The bin is zeroed when that position is below the width, or above sixteen minus the width. The low edge therefore loses `width` bins and the high edge loses `width - 1`. A width of zero turns the notch off. Every bin that is not notched leaves the block bit-identical to how it entered. The block adds one registered cycle of latency, and the valid flag and bin index travel with the data.

Top module: `dc_subframe_notch`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), out_valid, out_bin, out_i and out_q are all zero after that edge.
- R2: out_valid and out_bin at each clock edge equal in_valid and in_bin sampled at the previous edge (one-cycle latency).
- R3: A valid sample whose in-subframe position (in_bin bits 3:0) is less than notch_width leaves with out_i and out_q equal to zero.
- R4: A valid sample whose in-subframe position is greater than 16 minus notch_width leaves with zero I and Q. With width 1 the high edge is untouched. With width 3, position 14 is zeroed and position 13 is not.
- R5: A valid sample that is notched by neither edge leaves with out_i and out_q bit-identical to in_i and in_q.
- R6: When notch_width is 0, every bin passes unchanged.
- R7: Bins b and b+16 get identical treatment. With width 2, exactly global bins 0, 1, 15, 16, 17 and 31 are zeroed.
- R8: The width applied to a sample is the notch_width value present in the same cycle as that sample. A change in width takes effect on the very next beat.
- R9: When in_valid is low, out_i, out_q and out_bin keep their previous values.
- R10: With width 9 or more, every bin is zeroed. With width 8, only position 8 of each subframe passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| notch_width | input | 4 | Number of bins notched at each subframe low edge (0 = off) |
| in_valid | input | 1 | Input sample valid |
| in_bin | input | 5 | Doppler bin index of the input sample |
| in_i | input | 16 | Input in-phase sample (signed) |
| in_q | input | 16 | Input quadrature sample (signed) |
| out_valid | output | 1 | Output sample valid |
| out_bin | output | 5 | Doppler bin index of the output sample |
| out_i | output | 16 | Output in-phase sample (signed) |
| out_q | output | 16 | Output quadrature sample (signed) |

## Verification
Every result is due exactly one clock edge after the beat that caused it. This holds for the valid flag, the bin index, and the gated I/Q data, which uses the width presented on that same beat. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, after a single rising edge has passed. In streaming runs it compares the output of beat k-1 while presenting beat k. The idle-hold and reset checks are sampled at that same half-cycle offset, so each one sees exactly one register update.

// File: rtl/dcn_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the subframe Doppler notch.
// Assumes positions and widths fit comfortably in a 32-bit int.
package dcn_pkg;

    // Number of data lanes carried per sample (I and Q).
    localparam int LANES = 2;

    // Edge rule: low edge below width, high edge above span minus width.
    function automatic logic edge_hit(input int pos, input int width, input int span);
        return (pos < width) || (pos > (span - width));
    endfunction

endpackage

// File: rtl/dcn_bin_rule.sv
`timescale 1ns/1ps
// Module: dcn_bin_rule
// Decides, combinationally, whether a Doppler bin falls inside the notch.
// It assumes the subframe length is a power of two. The in-subframe
// position is therefore the low SUB_W bits of the bin index.
module dcn_bin_rule #(
    parameter int BIN_W = 5,
    parameter int SUB_W = 4,
    parameter int WID_W = 4
) (
    input  logic [BIN_W-1:0] bin,
    input  logic [WID_W-1:0] width,
    output logic             hit
);
    import dcn_pkg::*;

    localparam int SPAN = 1 << SUB_W;

    logic [SUB_W-1:0] pos;

    // Extract position inside the subframe and apply the edge rule.
    always_comb begin
        pos = bin[SUB_W-1:0];
        hit = edge_hit(int'(pos), int'(width), SPAN);
    end
endmodule

// File: rtl/dcn_lane_gate.sv
`timescale 1ns/1ps
// Module: dcn_lane_gate
// Forces one data lane to zero when the kill flag is set. Otherwise it
// passes the lane through unchanged. It is purely combinational.
module dcn_lane_gate #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              kill,
    output logic [DATA_W-1:0] dout
);
    // Select zero or the untouched input.
    always_comb begin
        dout = kill ? '0 : din;
    end
endmodule

// File: rtl/dcn_out_reg.sv
`timescale 1ns/1ps
// Module: dcn_out_reg
// Output register stage. The valid flag follows every cycle. The bin and
// lane data load only on valid beats and hold otherwise. Reset is
// synchronous and active low, and clears everything.
module dcn_out_reg #(
    parameter int BIN_W  = 5,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [BIN_W-1:0]  d_bin,
    input  logic [DATA_W-1:0] d_lane [LANES],
    output logic              q_valid,
    output logic [BIN_W-1:0]  q_bin,
    output logic [DATA_W-1:0] q_lane [LANES]
);
    // Track the valid flag with one cycle of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= d_valid;
    end

    // Capture the bin index on valid beats.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_bin <= '0;
        else if (d_valid) q_bin <= d_bin;
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Capture one data lane on valid beats.
            always_ff @(posedge clk) begin
                if (!rst_n)       q_lane[g] <= '0;
                else if (d_valid) q_lane[g] <= d_lane[g];
            end
        end
    endgenerate
endmodule

// File: rtl/dc_subframe_notch.sv
`timescale 1ns/1ps
// Module: dc_subframe_notch
// Zeroes the I/Q samples whose Doppler bin lies near either edge of its
// subframe, and passes all other bins bit-exact. Latency is one cycle.
// It assumes NUM_BINS is a multiple of the subframe length, and that the
// width is sampled together with each beat.
module dc_subframe_notch #(
    parameter int NUM_BINS = 32,
    parameter int SUB_BINS = 16,
    parameter int DATA_W   = 16,
    parameter int WID_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WID_W-1:0]         notch_width,
    input  logic                     in_valid,
    input  logic [$clog2(NUM_BINS)-1:0] in_bin,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic [$clog2(NUM_BINS)-1:0] out_bin,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);
    import dcn_pkg::*;

    localparam int BIN_W = $clog2(NUM_BINS);
    localparam int SUB_W = $clog2(SUB_BINS);

    logic              notch_hit;
    logic [DATA_W-1:0] lane_in  [LANES];
    logic [DATA_W-1:0] lane_gated [LANES];
    logic [DATA_W-1:0] lane_out [LANES];

    // Pack the incoming I and Q into lanes.
    always_comb begin
        lane_in[0] = in_i;
        lane_in[1] = in_q;
    end

    dcn_bin_rule #(
        .BIN_W (BIN_W),
        .SUB_W (SUB_W),
        .WID_W (WID_W)
    ) u_rule (
        .bin   (in_bin),
        .width (notch_width),
        .hit   (notch_hit)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_gate
            dcn_lane_gate #(.DATA_W(DATA_W)) u_gate (
                .din  (lane_in[g]),
                .kill (notch_hit),
                .dout (lane_gated[g])
            );
        end
    endgenerate

    dcn_out_reg #(
        .BIN_W  (BIN_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_bin   (in_bin),
        .d_lane  (lane_gated),
        .q_valid (out_valid),
        .q_bin   (out_bin),
        .q_lane  (lane_out)
    );

    // Unpack the registered lanes onto the output ports.
    always_comb begin
        out_i = lane_out[0];
        out_q = lane_out[1];
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    bin_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_bin == $past(in_bin));
    // R3
    low_edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_bin[SUB_W-1:0] < notch_width)) |=> (out_i == '0 && out_q == '0));
    // R6
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && notch_width == '0) |=> (out_i == $past(in_i) && out_q == $past(in_q)));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(out_bin)));
endmodule

// File: tb/sim_dc_subframe_notch.sv
`timescale 1ns/1ps
module sim_dc_subframe_notch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  notch_width;
    logic        in_valid;
    logic [4:0]  in_bin;
    logic signed [15:0] in_i, in_q;
    logic        out_valid;
    logic [4:0]  out_bin;
    logic signed [15:0] out_i, out_q;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dc_subframe_notch u0 (
        .clk(clk), .rst_n(rst_n), .notch_width(notch_width),
        .in_valid(in_valid), .in_bin(in_bin), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i), .out_q(out_q)
    );

    // Layout: {req[3:0], width[3:0], bin[4:0], i[15:0], q[15:0], exp_i[15:0], exp_q[15:0]}
    localparam int NV = 20;
    localparam logic [76:0] VEC [NV] = '{
        {4'd3,  4'd2, 5'd0,  16'h04D2, 16'hFFFB, 16'h0000, 16'h0000}, // R3 low edge
        {4'd3,  4'd2, 5'd1,  16'h1234, 16'h8001, 16'h0000, 16'h0000}, // R3
        {4'd5,  4'd2, 5'd2,  16'h1111, 16'h2222, 16'h1111, 16'h2222}, // R5 pass
        {4'd5,  4'd2, 5'd14, 16'hABCD, 16'h7FFF, 16'hABCD, 16'h7FFF}, // R5
        {4'd4,  4'd2, 5'd15, 16'h0F0F, 16'hF0F0, 16'h0000, 16'h0000}, // R4 high edge
        {4'd7,  4'd2, 5'd16, 16'h0101, 16'h0202, 16'h0000, 16'h0000}, // R7 second subframe
        {4'd7,  4'd2, 5'd17, 16'h0303, 16'h0404, 16'h0000, 16'h0000}, // R7
        {4'd7,  4'd2, 5'd18, 16'h0505, 16'h0606, 16'h0505, 16'h0606}, // R7
        {4'd7,  4'd2, 5'd31, 16'h0707, 16'h0808, 16'h0000, 16'h0000}, // R7
        {4'd6,  4'd0, 5'd0,  16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000}, // R6 off
        {4'd6,  4'd0, 5'd15, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001}, // R6
        {4'd3,  4'd1, 5'd0,  16'h2468, 16'h1357, 16'h0000, 16'h0000}, // R3 width 1
        {4'd4,  4'd1, 5'd15, 16'h2468, 16'h1357, 16'h2468, 16'h1357}, // R4 width 1 high edge open
        {4'd4,  4'd3, 5'd13, 16'h4321, 16'h8765, 16'h4321, 16'h8765}, // R4 width 3 pos 13 passes
        {4'd4,  4'd3, 5'd14, 16'h4321, 16'h8765, 16'h0000, 16'h0000}, // R4 width 3 pos 14 zeroed
        {4'd5,  4'd3, 5'd3,  16'h0AAA, 16'h0BBB, 16'h0AAA, 16'h0BBB}, // R5
        {4'd10, 4'd8, 5'd8,  16'h1357, 16'h2468, 16'h1357, 16'h2468}, // R10 width 8 pos 8
        {4'd10, 4'd8, 5'd23, 16'h1357, 16'h2468, 16'h0000, 16'h0000}, // R10 width 8 pos 7
        {4'd10, 4'd9, 5'd24, 16'h1357, 16'h2468, 16'h0000, 16'h0000}, // R10 width 9
        {4'd10, 4'd15,5'd8,  16'h5A5A, 16'hA5A5, 16'h0000, 16'h0000}  // R10 width 15
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_hit(input int w, input int b);
        int p;
        p = b % 16;
        return (p < w) || (p > 16 - w);
    endfunction

    task automatic drive(input logic v, input logic [3:0] w, input logic [4:0] b,
                         input logic [15:0] i, input logic [15:0] q);
        in_valid = v; notch_width = w; in_bin = b; in_i = i; in_q = q;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_i, last_q;
        logic [4:0]  last_b;
        rst_n = 1'b0;
        drive(1'b1, 4'd0, 5'd9, 16'h1234, 16'h5678);
        repeat (3) @(negedge clk);
        // R1: reset state even with valid input present
        check(out_valid == 1'b0, "R1 valid", {31'd0, out_valid}, 0);
        check(out_i == 0 && out_q == 0, "R1 data", {out_i, out_q}, 0);
        check(out_bin == 0, "R1 bin", {27'd0, out_bin}, 0);
        drive(1'b0, 4'd0, 5'd0, 16'h0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: drive on falling edge, check after one rising edge.
        for (int k = 0; k < NV; k++) begin
            logic [76:0] v;
            v = VEC[k];
            drive(1'b1, v[72:69], v[68:64], v[63:48], v[47:32]);
            @(negedge clk);
            check(out_valid == 1'b1, $sformatf("R2 valid vec %0d", k), {31'd0, out_valid}, 1);
            check(out_bin == v[68:64], $sformatf("R2 bin vec %0d", k), {27'd0, out_bin}, {27'd0, v[68:64]});
            check({out_i, out_q} == v[31:0], $sformatf("R%0d data vec %0d", v[76:73], k),
                  {out_i, out_q}, v[31:0]);
        end
        last_i = out_i; last_q = out_q; last_b = out_bin;

        // R9: idle beats hold data; R2: valid drops
        drive(1'b0, 4'd0, 5'd3, 16'h5555, 16'h6666);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle valid", {31'd0, out_valid}, 0);
        check({out_i, out_q} == {last_i, last_q}, "R9 hold data", {out_i, out_q}, {last_i, last_q});
        check(out_bin == last_b, "R9 hold bin", {27'd0, out_bin}, {27'd0, last_b});
        @(negedge clk);
        check({out_i, out_q} == {last_i, last_q}, "R9 hold data 2", {out_i, out_q}, {last_i, last_q});

        // R8: back-to-back stream with width changing every beat
        begin
            logic [15:0] pi, pq;
            logic [4:0]  pb;
            int pw;
            for (int k = 0; k <= 64; k++) begin
                if (k > 0) begin
                    logic [31:0] e;
                    e = model_hit(pw, int'(pb)) ? 32'd0 : {pi, pq};
                    check(out_valid && out_bin == pb, "R8 stream tag", {26'd0, out_valid, out_bin}, {26'd0, 1'b1, pb});
                    check({out_i, out_q} == e, "R8 stream data", {out_i, out_q}, e);
                end
                if (k < 64) begin
                    pw = k % 5;
                    pb = 5'(k % 32);
                    pi = 16'(k * 257 + 3);
                    pq = 16'(16'hC000 - k * 99);
                    drive(1'b1, 4'(pw), pb, pi, pq);
                end else begin
                    drive(1'b0, 4'd0, 5'd0, 16'h0, 16'h0);
                end
                @(negedge clk);
            end
        end

        // R7: width 2 zeroes exactly 0,1,15,16,17,31
        for (int b = 0; b < 32; b++) begin
            bit z;
            z = (b == 0) || (b == 1) || (b == 15) || (b == 16) || (b == 17) || (b == 31);
            drive(1'b1, 4'd2, 5'(b), 16'(b + 16'h0100), 16'(16'h7000 - b));
            @(negedge clk);
            check({out_i, out_q} == (z ? 32'd0 : {16'(b + 16'h0100), 16'(16'h7000 - b)}),
                  $sformatf("R7 width2 bin %0d", b), {out_i, out_q},
                  z ? 32'd0 : {16'(b + 16'h0100), 16'(16'h7000 - b)});
        end

        // R10: width 9 zeroes every bin; R6: width 0 passes every bin
        for (int b = 0; b < 32; b++) begin
            drive(1'b1, 4'd9, 5'(b), 16'h7ABC, 16'h8123);
            @(negedge clk);
            check({out_i, out_q} == 32'd0, $sformatf("R10 width9 bin %0d", b), {out_i, out_q}, 0);
            drive(1'b1, 4'd0, 5'(b), 16'h7ABC, 16'h8123);
            @(negedge clk);
            check({out_i, out_q} == 32'h7ABC8123, $sformatf("R6 width0 bin %0d", b), {out_i, out_q}, 32'h7ABC8123);
        end

        // R1: reset mid-stream clears outputs
        rst_n = 1'b0;
        drive(1'b1, 4'd0, 5'd5, 16'h1111, 16'h2222);
        @(negedge clk);
        check(out_valid == 0 && out_bin == 0 && out_i == 0 && out_q == 0, "R1 mid reset",
              {out_i, out_q}, 0);
        drive(1'b0, 4'd0, 5'd0, 16'h0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule